// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit converts a selector:offset pair into a 32-bit linear address. It also reports how many bytes can be reached from that address inside the segment, and it returns a status code. The caller fetches the 64-bit segment descriptor that the selector names and presents it with the request. The caller also supplies the current byte limits of the global and local descriptor tables, so that the unit can reject selectors that point past the end of their table.

The unit has two translation paths. In real or virtual-8086 mode the segment is the selector times sixteen, and no check is made. In protected mode the unit takes the base and limit out of the descriptor and checks them. The meaning of the limit depends on the descriptor type: normal and conforming segments, expand-down data segments and system descriptors each use their own bound. Each request is accepted on a single-cycle strobe. The result is registered and appears one cycle later with a one-cycle valid pulse.

Top module: `seg_xlate`

## Requirements
- R1: With `legacy_mode` high, the linear address is `ofs[15:0]` plus `sel` shifted left by 4. The remaining count is 0x10000 minus `ofs[15:0]`. Status is 0 (success), whatever the descriptor holds.
- R2: In protected mode, `sel[2]`=1 picks the local table limit and `sel[2]`=0 picks the global table limit. The selector with bits [2:0] cleared must be strictly below the picked limit, or status is 1 (invalid selector). When `hyper` is high, this bound check is skipped for the global table only.
- R3: The descriptor fields sit at these bit positions:
  - base[15:0] at bits [31:16], base[23:16] at bits [39:32] and base[31:24] at bits [63:56];
  - limit[15:0] at bits [15:0] and limit[19:16] at bits [51:48];
  - type at bits [43:40], S at bit 44, present at bit 47 and granularity at bit 55.
  The linear address is the offset plus the base, modulo 2^32.
- R4: When the granularity bit is set, the 20-bit raw limit is shifted left by 12 and its low 12 bits are filled with ones. When the bit is clear, the raw limit is used as it is.
- R5: A clear present bit gives status 2 (not present) in protected mode. This check outranks the table bound check and every type or limit check.
- R6: For S=1 types other than expand-down data (type bit 3 = 1, or type bit 2 = 0), an offset above the limit gives status 3 (out of bounds). Otherwise the remaining count is the limit minus the offset plus 1.
- R7: For expand-down data types (S=1, type 4 to 7), the bound is 0xFFFFFFFF when granularity is set and 0xFFFFF when it is clear. If the bound minus the offset (modulo 2^32) exceeds the limit, status is 3. Otherwise the remaining count is the bound minus the offset plus 1.
- R8: For S=0 types 1 to 7, 9, 11, 12, 14 and 15, an offset above the limit gives status 3. Otherwise the remaining count is 2^32 minus the linear address.
- R9: S=0 types 0, 8, 10 and 13 give status 1.
- R10: `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high. Status takes only the codes 0 to 3. The result outputs hold their values until the next request.
- R11: A synchronous active-high reset clears `rsp_vld` and `status` to 0.
- R12: Whenever status is not 0, `lin_addr` and `remain` are 0. `remain` is 33 bits wide, so a full 4 GiB span reads as 0x1_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe, one cycle per translation |
| legacy_mode | input | 1 | 1 = real or virtual-8086 addressing, 0 = protected |
| sel | input | 16 | Segment selector |
| ofs | input | 32 | Offset within the segment |
| hyper | input | 1 | Skip the global table bound check |
| desc | input | 64 | Descriptor named by the selector |
| gdt_lim | input | TBL_LIM_W | Global table byte limit |
| ldt_lim | input | TBL_LIM_W | Local table byte limit |
| rsp_vld | output | 1 | Result valid pulse |
| lin_addr | output | 32 | Linear address |
| remain | output | 33 | Bytes reachable from the linear address |
| status | output | 3 | 0 ok, 1 invalid selector, 2 not present, 3 out of bounds |

## Verification
The bench builds the unit with its default parameters:
- `PG_SHIFT` = 12, so granular limits end in 0xFFF and reach the full 4 GiB span, which tests the 33-bit `remain` at 2^32.
- `TBL_LIM_W` = 17, so a table limit of 0x10000 admits every selector, while smaller limits allow exact tests one entry inside and one entry outside the table.

Random offsets are placed within a few bytes of each type's bound, so both sides of every limit comparison are exercised.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int PG_SHIFT  = 12,
  parameter int TBL_LIM_W = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_vld,
  input  logic                 legacy_mode,
  input  logic [15:0]          sel,
  input  logic [31:0]          ofs,
  input  logic                 hyper,
  input  logic [63:0]          desc,
  input  logic [TBL_LIM_W-1:0] gdt_lim,
  input  logic [TBL_LIM_W-1:0] ldt_lim,
  output logic                 rsp_vld,
  output logic [31:0]          lin_addr,
  output logic [32:0]          remain,
  output logic [2:0]           status
);

  localparam logic [2:0]  ST_OK     = 3'd0;
  localparam logic [2:0]  ST_BADSEL = 3'd1;
  localparam logic [2:0]  ST_ABSENT = 3'd2;
  localparam logic [2:0]  ST_OOB    = 3'd3;
  localparam logic [15:0] SYS_KNOWN = 16'hDAFE;
  localparam logic [31:0] PG_FILL   = (32'd1 << PG_SHIFT) - 32'd1;

  // descriptor fields
  wire [31:0] d_base = {desc[63:56], desc[39:32], desc[31:16]};
  wire [19:0] d_raw  = {desc[51:48], desc[15:0]};
  wire [3:0]  d_type = desc[43:40];
  wire        d_s    = desc[44];
  wire        d_p    = desc[47];
  wire        d_g    = desc[55];

  wire [31:0] lim     = d_g ? ((32'(d_raw) << PG_SHIFT) | PG_FILL) : 32'(d_raw);
  wire [31:0] xd_bnd  = d_g ? 32'hFFFF_FFFF : 32'h000F_FFFF;
  wire        is_xd   = d_s && !d_type[3] && d_type[2];
  wire        sys_ok  = SYS_KNOWN[d_type];

  // table bound
  wire [TBL_LIM_W-1:0] sel_bytes = TBL_LIM_W'({sel[15:3], 3'b000});
  wire [TBL_LIM_W-1:0] tbl_lim   = sel[2] ? ldt_lim : gdt_lim;
  wire                 tbl_skip  = !sel[2] && hyper;
  wire                 tbl_bad   = !tbl_skip && (sel_bytes >= tbl_lim);

  // address and spans
  wire [31:0] prot_lin = ofs + d_base;
  wire [31:0] real_lin = 32'(ofs[15:0]) + {12'd0, sel, 4'd0};
  wire [31:0] xd_gap   = xd_bnd - ofs;
  wire        over_lim = ofs > lim;
  wire        xd_over  = xd_gap > lim;

  logic [2:0]  n_st;
  logic [31:0] n_lin;
  logic [32:0] n_rem;

  always_comb begin
    n_st  = ST_OK;
    n_lin = prot_lin;
    n_rem = 33'd0;
    if (legacy_mode) begin
      n_lin = real_lin;
      n_rem = 33'h1_0000 - 33'(ofs[15:0]);
    end else if (!d_p) begin
      n_st = ST_ABSENT;
    end else if (tbl_bad) begin
      n_st = ST_BADSEL;
    end else if (d_s) begin
      if (is_xd) begin
        if (xd_over) n_st = ST_OOB;
        else         n_rem = 33'(xd_gap) + 33'd1;
      end else begin
        if (over_lim) n_st = ST_OOB;
        else          n_rem = 33'(lim - ofs) + 33'd1;
      end
    end else if (!sys_ok) begin
      n_st = ST_BADSEL;
    end else if (over_lim) begin
      n_st = ST_OOB;
    end else begin
      n_rem = 33'h1_0000_0000 - 33'(prot_lin);
    end
    if (n_st != ST_OK) begin
      n_lin = 32'd0;
      n_rem = 33'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld <= 1'b0;
      status  <= ST_OK;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) status <= n_st;
    end
  end

  always_ff @(posedge clk) begin
    if (req_vld) begin
      lin_addr <= n_lin;
      remain   <= n_rem;
    end
  end

  // checks
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);
  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> ($stable(status) && $stable(lin_addr) && $stable(remain)));
  p_code_range_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> (status <= ST_OOB));
  p_absent_first_r5: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !legacy_mode && !desc[47]) |=> (status == ST_ABSENT));
  p_real_span_r1: assert property (@(posedge clk) disable iff (rst)
    (req_vld && legacy_mode) |=>
      (status == ST_OK && remain == 33'h1_0000 - 33'($past(ofs[15:0]))));
  p_fail_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && status != ST_OK) |-> (lin_addr == 32'd0 && remain == 33'd0));

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic        legacy_mode = 1'b0;
  logic [15:0] sel = '0;
  logic [31:0] ofs = '0;
  logic        hyper = 1'b0;
  logic [63:0] desc = '0;
  logic [16:0] gdt_lim = '0;
  logic [16:0] ldt_lim = '0;
  logic        rsp_vld;
  logic [31:0] lin_addr;
  logic [32:0] remain;
  logic [2:0]  status;

  int checks = 0;
  int fails  = 0;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst(rst), .req_vld(req_vld), .legacy_mode(legacy_mode),
    .sel(sel), .ofs(ofs), .hyper(hyper), .desc(desc),
    .gdt_lim(gdt_lim), .ldt_lim(ldt_lim),
    .rsp_vld(rsp_vld), .lin_addr(lin_addr), .remain(remain), .status(status));

  always #4 clk = ~clk;

  function automatic logic [63:0] mk_desc(logic [31:0] base, logic [19:0] rl,
                                          logic s, logic [3:0] t, logic p, logic g);
    logic [63:0] d = '0;
    d[15:0] = rl[15:0];  d[51:48] = rl[19:16];
    d[31:16] = base[15:0]; d[39:32] = base[23:16]; d[63:56] = base[31:24];
    d[43:40] = t; d[44] = s; d[47] = p; d[55] = g;
    return d;
  endfunction

  function automatic logic [31:0] d_limit(logic [63:0] d);
    logic [31:0] l = {12'd0, d[51:48], d[15:0]};
    if (d[55]) l = l * 32'd4096 + 32'd4095;
    return l;
  endfunction

  function automatic logic sys_known(logic [3:0] t);
    case (t)
      4'd0, 4'd8, 4'd10, 4'd13: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // returns {status, lin, remain}
  function automatic logic [67:0] model(logic lg, logic [15:0] s, logic [31:0] o, logic hy,
                                        logic [63:0] d, logic [16:0] gl, logic [16:0] ll);
    logic [2:0] st = 3'd0;
    logic [31:0] ln = '0;
    logic [32:0] rm = '0;
    logic [31:0] base = {d[63:56], d[39:32], d[31:16]};
    logic [31:0] lm = d_limit(d);
    logic [3:0] t = d[43:40];
    logic [31:0] bnd = d[55] ? 32'hFFFFFFFF : 32'hFFFFF;
    logic [16:0] idx = {1'b0, s & 16'hFFF8};
    if (lg) begin
      ln = {16'd0, o[15:0]} + {12'd0, s, 4'd0};
      rm = 33'd65536 - {17'd0, o[15:0]};
    end else if (!d[47]) st = 3'd2;
    else if ((s[2] && idx >= ll) || (!s[2] && !hy && idx >= gl)) st = 3'd1;
    else begin
      ln = o + base;
      if (d[44] && t[3:2] == 2'b01) begin
        if (bnd - o > lm) st = 3'd3; else rm = {1'b0, bnd} - {1'b0, o} + 33'd1;
      end else if (d[44]) begin
        if (o > lm) st = 3'd3; else rm = {1'b0, lm} - {1'b0, o} + 33'd1;
      end else if (!sys_known(t)) st = 3'd1;
      else if (o > lm) st = 3'd3;
      else rm = 33'h1_0000_0000 - {1'b0, ln};
    end
    if (st != 0) begin ln = '0; rm = '0; end
    return {st, ln, rm};
  endfunction

  function automatic string tag(logic lg, logic [63:0] d, logic [2:0] st, logic hy);
    string t;
    if (lg) return "R1";
    if (!d[47]) return "R5";
    if (!d[44] && !sys_known(d[43:40])) t = "R9";
    else if (d[44] && d[43:42] == 2'b01) t = "R7";
    else if (d[44]) t = "R6";
    else t = "R8";
    if (st == 3'd1 && t != "R9") t = "R2";
    if (d[55]) t = {t, "/R4"};
    if (hy) t = {t, "/R2"};
    if (st != 0) t = {t, "/R12"};
    else t = {t, "/R3"};
    return t;
  endfunction

  task automatic check(bit ok, string req, string what, logic [67:0] act, logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(logic lg, logic [15:0] s, logic [31:0] o, logic hy,
                     logic [63:0] d, logic [16:0] gl, logic [16:0] ll, bit idle_chk);
    logic [67:0] exp = model(lg, s, o, hy, d, gl, ll);
    logic [67:0] act;
    string t = tag(lg, d, exp[67:65], hy);
    @(negedge clk);
    legacy_mode = lg; sel = s; ofs = o; hyper = hy; desc = d;
    gdt_lim = gl; ldt_lim = ll; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    desc = ~d; ofs = ~o;
    act = {status, lin_addr, remain};
    check(rsp_vld === 1'b1, "R10", "rsp_vld after request", {67'd0, rsp_vld}, 68'd1);
    check(act === exp, t, "result", act, exp);
    if (idle_chk) begin
      @(negedge clk);
      check(rsp_vld === 1'b0 && {status, lin_addr, remain} === exp, "R10",
            "pulse end and hold", {status, lin_addr, remain}, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_up();
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(rsp_vld === 1'b0 && status === 3'd0, "R11", "reset state",
          {65'd0, status}, 68'd0);
    rst = 1'b0;

    // R1 real mode wrap past 1 MiB
    run(1'b1, 16'hFFFF, 32'hFFFF_FFFF, 1'b0, 64'd0, 17'd0, 17'd0, 1'b1);
    // R5 absent outranks bad selector
    run(1'b0, 16'hFFF8, 32'd0, 1'b0, mk_desc(0, 20'hFFFFF, 1, 4'h2, 0, 0), 17'd8, 17'd8, 1'b1);
    // R2 hyper skips global bound but not local
    d = mk_desc(32'h1000, 20'hFFFF, 1, 4'h2, 1, 0);
    run(1'b0, 16'h0800, 32'h10, 1'b1, d, 17'h10, 17'h10000, 1'b0);
    run(1'b0, 16'h0804, 32'h10, 1'b1, d, 17'h10000, 17'h10, 1'b0);
    run(1'b0, 16'h0800, 32'h10, 1'b0, d, 17'h808, 17'h0, 1'b0);
    run(1'b0, 16'h0800, 32'h10, 1'b0, d, 17'h800, 17'h0, 1'b0);
    // R4/R6 full 4 GiB span
    run(1'b0, 16'h0008, 32'd0, 1'b0, mk_desc(0, 20'hFFFFF, 1, 4'hA, 1, 1), 17'h10000, 0, 1'b1);
    // R7 expand-down beyond 1 MiB without granularity, and exact edge
    d = mk_desc(32'h0, 20'h00100, 1, 4'h6, 1, 0);
    run(1'b0, 16'h0008, 32'h0010_0000, 1'b0, d, 17'h10000, 0, 1'b0);
    run(1'b0, 16'h0008, 32'h000F_FEFF, 1'b0, d, 17'h10000, 0, 1'b0);
    run(1'b0, 16'h0008, 32'h000F_FEFE, 1'b0, d, 17'h10000, 0, 1'b0);
    // R9 undefined system type
    run(1'b0, 16'h0008, 32'd0, 1'b0, mk_desc(0, 20'hFFFFF, 0, 4'h8, 1, 0), 17'h10000, 0, 1'b0);
    // R8/R3 system type with base wrap
    run(1'b0, 16'h0008, 32'h20, 1'b0, mk_desc(32'hFFFF_FFF0, 20'h67, 0, 4'h9, 1, 0), 17'h10000, 0, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      logic lg = ($urandom % 6) == 0;
      logic [15:0] s = $urandom;
      logic hy = ($urandom % 4) == 0;
      logic [16:0] gl = ($urandom % 3 == 0) ? 17'h10000 : 17'($urandom % 17'h10001);
      logic [16:0] ll = ($urandom % 3 == 0) ? 17'h10000 : 17'($urandom % 17'h10001);
      logic [19:0] rl = ($urandom % 2) ? 20'($urandom % 64) : 20'($urandom);
      logic [31:0] o;
      logic [31:0] lm;
      logic [31:0] bnd;
      d = mk_desc($urandom, rl, ($urandom % 3) != 0, 4'($urandom), ($urandom % 8) != 0,
                  $urandom % 2);
      lm = d_limit(d);
      bnd = d[55] ? 32'hFFFFFFFF : 32'hFFFFF;
      case ($urandom % 3)
        0: o = $urandom;
        1: o = lm + 32'($urandom % 5) - 32'd2;
        default: o = bnd - lm + 32'($urandom % 5) - 32'd2;
      endcase
      run(lg, s, o, hy, d, gl, ll, (i % 16) == 0);
    end

    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(rsp_vld === 1'b0 && status === 3'd0, "R11", "reset after traffic",
          {65'd0, status}, 68'd0);
    finish_up();
  end
endmodule